// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block takes control of a small 16-bit segmented CPU core whenever an interrupt is accepted, and it also carries out the return from an interrupt handler. At each instruction boundary the core raises a strobe. On that strobe the block looks at four sources: a non-maskable request that fires on a rising edge, a software interrupt with its own type number, a single-step trap that comes from the trap flag, and a level-sensitive maskable request whose type number arrives on an acknowledge input. Requests that arrive between boundaries wait for the next one. The only exception is a non-maskable edge, which is latched at once and so is never lost.

On entry the block pushes the core's flag word, code segment and instruction pointer onto a word-wide stack in memory. It then reads the handler's instruction pointer and code segment from a vector table at the bottom of memory. It returns the new register values together with flags in which the interrupt-enable and trap bits are cleared. A return strobe starts the reverse sequence, which pops the instruction pointer, the code segment and the flags. The core loads the results during a one-cycle done pulse. A simple synchronous memory port is used: a write completes in its request cycle, and read data is valid in the cycle after the request.

Top module: `irq_seq`

## Requirements
- R1: When idle, the block samples requests only in a cycle where `boundary_i` or `iret_i` is high. Between boundaries, `intr_i`, `swi_req_i` and the flags have no effect: `busy_o` stays low and no memory access is made.
- R2: `intr_i` is level-sensitive. It is accepted at a boundary only when flag bit 9 (interrupt enable) is 1, and it then uses the type number on `ack_type_i`.
- R3: A 0-to-1 transition on `nmi_i` is latched even while the block is busy. It is serviced at the next accepted boundary as type 2, whatever the value of flag bit 9. A level that stays high does not fire again.
- R4: At one boundary the order of precedence is: non-maskable first, then software interrupt (`swi_type_i`), then trap (type 1, raised when flag bit 8 is 1), then the maskable request.
- R5: Entry writes three words on three consecutive cycles, starting the cycle after acceptance: the flags at SS:(SP-2), CS at SS:(SP-4) and IP at SS:(SP-6). A physical address is SS*16 + offset, taken modulo 2^20.
- R6: Stack offset arithmetic wraps modulo 2^16. An entry with SP=0 writes at offset 0xFFFE, and a pop past 0xFFFE continues at 0x0000.
- R7: After the pushes, the vector for type n is read at physical address n*4, which gives the new IP, and then at n*4+2, which gives the new CS.
- R8: On entry, `new_flags_o` equals the saved flag word with bits 9 and 8 cleared and every other bit unchanged. The pushed flag word is the original value. `new_sp_o` is SP-6.
- R9: A return reads SS:SP, SS:SP+2 and SS:SP+4 on consecutive cycles into IP, CS and flags, and sets `new_sp_o` to SP+6.
- R10: `busy_o` is high for exactly 6 cycles after an entry is accepted, or 4 cycles after a return is accepted. Then `done_o` is high for one cycle, with `busy_o` low and the `new_*` outputs valid.
- R11: After reset, `busy_o`, `done_o` and `mem_req_o` are low and no non-maskable request is pending.
- R12: If `iret_i` and `boundary_i` are both high in the same idle cycle, the return is performed and the boundary sources are not serviced in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction boundary strobe |
| iret_i | input | 1 | Return-from-interrupt strobe |
| intr_i | input | 1 | Maskable request, level-sensitive |
| nmi_i | input | 1 | Non-maskable request, rising-edge |
| swi_req_i | input | 1 | Software interrupt request |
| swi_type_i | input | 8 | Software interrupt type number |
| ack_type_i | input | 8 | Type number supplied for the maskable request |
| flags_i | input | 16 | Core flag word |
| cs_i | input | 16 | Core code segment |
| ip_i | input | 16 | Core instruction pointer |
| ss_i | input | 16 | Core stack segment |
| sp_i | input | 16 | Core stack pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when 1, read when 0 |
| mem_addr_o | output | 20 | Physical word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid one cycle after request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| new_ip_o | output | 16 | IP to load at done |
| new_cs_o | output | 16 | CS to load at done |
| new_flags_o | output | 16 | Flag word to load at done |
| new_sp_o | output | 16 | SP to load at done |

## Verification
The checker watches the handshake shape on every cycle. It confirms that memory is touched only while busy, that writes always carry a request, that done is a lone pulse which never overlaps busy, that busy always ends in done, and that an idle block with no strobe stays idle. Only the bench scenarios can show the content of the sequences: the order of source precedence, the edge rule for the non-maskable request, flag masking, the address values of the stack and vector table including wrap at offset 0, and the round trip in which an entry's frame is later popped back intact.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    localparam int WORD_W       = 16;
    localparam int SEG_SHIFT    = 4;
    localparam int ADDR_W       = WORD_W + SEG_SHIFT;
    localparam int TYPE_W       = 8;
    localparam int IF_POS       = 9;
    localparam int TF_POS       = 8;
    localparam int NMI_VEC      = 2;
    localparam int TRAP_VEC     = 1;
    localparam int ENTRY_PUSHES = 3;
    localparam int VEC_READS    = 2;
    localparam int RET_POPS     = 3;
    localparam int SLOTS        = RET_POPS;
    localparam int STEP_W       = $clog2(SLOTS + 1);
    localparam int WORD_BYTES   = 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] paddr_t;
    typedef logic [TYPE_W-1:0] vtype_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PUSH, ST_VREAD, ST_POP, ST_DRAIN, ST_DONE
    } state_e;

    typedef struct packed {
        logic   go_int;
        logic   go_ret;
        vtype_t vtype;
    } accept_t;

    function automatic paddr_t phys(input word_t seg, input word_t off);
        return {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off};
    endfunction

    function automatic paddr_t vec_addr(input vtype_t t, input logic hi);
        return {{(ADDR_W-TYPE_W-2){1'b0}}, t, hi, 1'b0};
    endfunction

    function automatic word_t mask_entry(input word_t f);
        word_t m;
        m = f;
        m[IF_POS] = 1'b0;
        m[TF_POS] = 1'b0;
        return m;
    endfunction

    function automatic word_t step_ofs(input step_t s);
        return {{(WORD_W-STEP_W-1){1'b0}}, s, 1'b0};
    endfunction
endpackage

// File: rtl/irq_src_arb.sv
module irq_src_arb
    import irq_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    idle_i,
    input  logic    boundary_i,
    input  logic    iret_i,
    input  logic    intr_i,
    input  logic    nmi_i,
    input  logic    swi_req_i,
    input  vtype_t  swi_type_i,
    input  vtype_t  ack_type_i,
    input  logic    if_i,
    input  logic    tf_i,
    output accept_t acc_o
);
    logic nmi_prev_q, nmi_pend_q, nmi_rise, nmi_live, take_nmi;

    assign nmi_rise = nmi_i & ~nmi_prev_q;
    assign nmi_live = nmi_pend_q | nmi_rise;

    always_comb begin
        acc_o    = '0;
        take_nmi = 1'b0;
        if (idle_i) begin
            if (iret_i) begin
                acc_o.go_ret = 1'b1;
            end else if (boundary_i) begin
                if (nmi_live) begin
                    acc_o.go_int = 1'b1;
                    acc_o.vtype  = vtype_t'(NMI_VEC);
                    take_nmi     = 1'b1;
                end else if (swi_req_i) begin
                    acc_o.go_int = 1'b1;
                    acc_o.vtype  = swi_type_i;
                end else if (tf_i) begin
                    acc_o.go_int = 1'b1;
                    acc_o.vtype  = vtype_t'(TRAP_VEC);
                end else if (intr_i && if_i) begin
                    acc_o.go_int = 1'b1;
                    acc_o.vtype  = ack_type_i;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev_q <= 1'b0;
            nmi_pend_q <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_i;
            nmi_pend_q <= nmi_live & ~take_nmi;
        end
    end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   go_int_i,
    input  logic   go_ret_i,
    output state_e state_o,
    output step_t  step_o,
    output logic   ret_mode_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state_o    <= ST_IDLE;
            step_o     <= '0;
            ret_mode_o <= 1'b0;
        end else begin
            case (state_o)
                ST_IDLE: begin
                    step_o <= '0;
                    if (go_ret_i) begin
                        state_o    <= ST_POP;
                        ret_mode_o <= 1'b1;
                    end else if (go_int_i) begin
                        state_o    <= ST_PUSH;
                        ret_mode_o <= 1'b0;
                    end
                end
                ST_PUSH: begin
                    if (step_o == step_t'(ENTRY_PUSHES-1)) begin
                        state_o <= ST_VREAD;
                        step_o  <= '0;
                    end else begin
                        step_o <= step_o + 1'b1;
                    end
                end
                ST_VREAD: begin
                    if (step_o == step_t'(VEC_READS-1)) begin
                        state_o <= ST_DRAIN;
                        step_o  <= '0;
                    end else begin
                        step_o <= step_o + 1'b1;
                    end
                end
                ST_POP: begin
                    if (step_o == step_t'(RET_POPS-1)) begin
                        state_o <= ST_DRAIN;
                        step_o  <= '0;
                    end else begin
                        step_o <= step_o + 1'b1;
                    end
                end
                ST_DRAIN: state_o <= ST_DONE;
                default:  state_o <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              boundary_i,
    input  logic              iret_i,
    input  logic              intr_i,
    input  logic              nmi_i,
    input  logic              swi_req_i,
    input  logic [TYPE_W-1:0] swi_type_i,
    input  logic [TYPE_W-1:0] ack_type_i,
    input  logic [WORD_W-1:0] flags_i,
    input  logic [WORD_W-1:0] cs_i,
    input  logic [WORD_W-1:0] ip_i,
    input  logic [WORD_W-1:0] ss_i,
    input  logic [WORD_W-1:0] sp_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [WORD_W-1:0] new_ip_o,
    output logic [WORD_W-1:0] new_cs_o,
    output logic [WORD_W-1:0] new_flags_o,
    output logic [WORD_W-1:0] new_sp_o
);
    state_e  state;
    step_t   step;
    logic    ret_mode;
    accept_t acc;
    word_t   ss_q, sp_q, fl_q, cs_q, ip_q;
    vtype_t  vt_q;
    logic    rd_go, rd_v_q;
    step_t   rd_idx_q;
    word_t   slot_q [SLOTS];

    irq_src_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .idle_i     (state == ST_IDLE),
        .boundary_i (boundary_i),
        .iret_i     (iret_i),
        .intr_i     (intr_i),
        .nmi_i      (nmi_i),
        .swi_req_i  (swi_req_i),
        .swi_type_i (swi_type_i),
        .ack_type_i (ack_type_i),
        .if_i       (flags_i[IF_POS]),
        .tf_i       (flags_i[TF_POS]),
        .acc_o      (acc)
    );

    irq_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .go_int_i   (acc.go_int),
        .go_ret_i   (acc.go_ret),
        .state_o    (state),
        .step_o     (step),
        .ret_mode_o (ret_mode)
    );

    // Capture the core context at acceptance.
    always_ff @(posedge clk) begin
        if (rst) begin
            ss_q <= '0; sp_q <= '0; fl_q <= '0;
            cs_q <= '0; ip_q <= '0; vt_q <= '0;
        end else if (acc.go_ret) begin
            ss_q <= ss_i;
            sp_q <= sp_i;
        end else if (acc.go_int) begin
            ss_q <= ss_i;
            sp_q <= sp_i;
            fl_q <= flags_i;
            cs_q <= cs_i;
            ip_q <= ip_i;
            vt_q <= acc.vtype;
        end
    end

    // Memory port driven from the current step.
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        case (state)
            ST_PUSH: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = phys(ss_q, sp_q - step_ofs(step) - word_t'(WORD_BYTES));
                case (step)
                    step_t'(0): mem_wdata_o = fl_q;
                    step_t'(1): mem_wdata_o = cs_q;
                    default:    mem_wdata_o = ip_q;
                endcase
            end
            ST_VREAD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = vec_addr(vt_q, step[0]);
            end
            ST_POP: begin
                mem_req_o  = 1'b1;
                mem_addr_o = phys(ss_q, sp_q + step_ofs(step));
            end
            default: ;
        endcase
    end

    assign rd_go = (state == ST_VREAD) || (state == ST_POP);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_v_q   <= 1'b0;
            rd_idx_q <= '0;
        end else begin
            rd_v_q   <= rd_go;
            rd_idx_q <= step;
        end
    end

    // One capture register per returned word.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (rd_v_q && (rd_idx_q == step_t'(g))) begin
                slot_q[g] <= mem_rdata_i;
            end
        end
    end

    assign busy_o      = (state == ST_PUSH) || (state == ST_VREAD) ||
                         (state == ST_POP)  || (state == ST_DRAIN);
    assign done_o      = (state == ST_DONE);
    assign new_ip_o    = slot_q[0];
    assign new_cs_o    = slot_q[1];
    assign new_flags_o = ret_mode ? slot_q[2] : mask_entry(fl_q);
    assign new_sp_o    = ret_mode ? sp_q + word_t'(WORD_BYTES*RET_POPS)
                                  : sp_q - word_t'(WORD_BYTES*ENTRY_PUSHES);
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk (
    input logic clk,
    input logic rst,
    input logic boundary,
    input logic iret,
    input logic mem_req,
    input logic mem_we,
    input logic busy,
    input logic done
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R1
    mem_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    // R5
    write_has_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

    // R1
    quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done && !boundary && !iret) |=> !busy);
endmodule

bind irq_seq irq_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .boundary (boundary_i),
    .iret     (iret_i),
    .mem_req  (mem_req_o),
    .mem_we   (mem_we_o),
    .busy     (busy_o),
    .done     (done_o)
);

// File: tb/test_irq_seq.sv
module test_irq_seq;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, boundary, iret, intr, nmi, swi_req;
    logic [7:0]  swi_type, ack_type;
    logic [15:0] flags_r, cs_r, ip_r, ss_r, sp_r;
    logic        mem_req, mem_we, busy, done;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata, new_ip, new_cs, new_flags, new_sp;

    irq_seq i_irq_seq (
        .clk(clk), .rst(rst), .boundary_i(boundary), .iret_i(iret),
        .intr_i(intr), .nmi_i(nmi), .swi_req_i(swi_req),
        .swi_type_i(swi_type), .ack_type_i(ack_type),
        .flags_i(flags_r), .cs_i(cs_r), .ip_i(ip_r), .ss_i(ss_r), .sp_i(sp_r),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .busy_o(busy), .done_o(done), .new_ip_o(new_ip), .new_cs_o(new_cs),
        .new_flags_o(new_flags), .new_sp_o(new_sp)
    );

    int n_chk = 0;
    int n_err = 0;

    // Behavioural memory: write in request cycle, read data one cycle later.
    logic [15:0] mem [int];

    function automatic logic [15:0] rdm(input logic [19:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return 16'h0000;
    endfunction

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[int'(mem_addr)] = mem_wdata;
        mem_rdata <= rdm(mem_addr);
    end

    function automatic logic [19:0] pa(input logic [15:0] seg, input logic [15:0] off);
        return {seg, 4'h0} + {4'h0, off};
    endfunction

    // Reference model: expected bus operations and results.
    logic [19:0] eq_addr [$];
    logic        eq_we   [$];
    logic [15:0] eq_data [$];
    logic [15:0] exp_ip, exp_cs, exp_flags, exp_sp;
    int          exp_busy;
    bit          exp_ret;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic add_op(input logic [19:0] a, input logic w, input logic [15:0] d);
        eq_addr.push_back(a);
        eq_we.push_back(w);
        eq_data.push_back(d);
    endtask

    task automatic model_entry(input logic [7:0] t);
        logic [19:0] va;
        va = {10'h0, t, 2'b00};
        add_op(pa(ss_r, sp_r - 16'd2), 1'b1, flags_r);
        add_op(pa(ss_r, sp_r - 16'd4), 1'b1, cs_r);
        add_op(pa(ss_r, sp_r - 16'd6), 1'b1, ip_r);
        add_op(va, 1'b0, 16'h0);
        add_op(va + 20'd2, 1'b0, 16'h0);
        exp_ip    = rdm(va);
        exp_cs    = rdm(va + 20'd2);
        exp_flags = flags_r & 16'hFCFF;
        exp_sp    = sp_r - 16'd6;
        exp_busy  = 6;
        exp_ret   = 1'b0;
    endtask

    task automatic model_return();
        add_op(pa(ss_r, sp_r), 1'b0, 16'h0);
        add_op(pa(ss_r, sp_r + 16'd2), 1'b0, 16'h0);
        add_op(pa(ss_r, sp_r + 16'd4), 1'b0, 16'h0);
        exp_ip    = rdm(pa(ss_r, sp_r));
        exp_cs    = rdm(pa(ss_r, sp_r + 16'd2));
        exp_flags = rdm(pa(ss_r, sp_r + 16'd4));
        exp_sp    = sp_r + 16'd6;
        exp_busy  = 4;
        exp_ret   = 1'b1;
    endtask

    // Strobes are set at a falling edge and dropped just after the rising edge.
    task automatic strobe(input bit b, input bit r, input bit s);
        @(negedge clk);
        boundary = b; iret = r; swi_req = s;
        @(posedge clk);
        #1;
        boundary = 1'b0; iret = 1'b0; swi_req = 1'b0;
    endtask

    // Compare every cycle against the model until done.
    task automatic observe(input string sc);
        int  bcnt = 0;
        bit  seen = 0;
        for (int c = 0; c < 20 && !seen; c++) begin
            @(negedge clk);
            if (mem_req) begin
                if (eq_addr.size() == 0) begin
                    chk({sc, " R1 unexpected access"}, 1, 0);
                end else begin
                    logic [19:0] a;
                    logic        w;
                    logic [15:0] d;
                    a = eq_addr.pop_front();
                    w = eq_we.pop_front();
                    d = eq_data.pop_front();
                    if (w) begin
                        chk({sc, " R5 write addr"}, 32'(mem_addr), 32'(a));
                        chk({sc, " R5 write flag"}, 32'(mem_we), 32'(w));
                        chk({sc, " R5 write data"}, 32'(mem_wdata), 32'(d));
                    end else if (exp_ret) begin
                        chk({sc, " R9 pop addr"}, 32'(mem_addr), 32'(a));
                        chk({sc, " R9 pop is read"}, 32'(mem_we), 32'(w));
                    end else begin
                        chk({sc, " R7 vector addr"}, 32'(mem_addr), 32'(a));
                        chk({sc, " R7 vector is read"}, 32'(mem_we), 32'(w));
                    end
                end
            end
            if (busy) bcnt++;
            if (done) begin
                seen = 1;
                chk({sc, exp_ret ? " R9 ip" : " R7 ip"}, 32'(new_ip), 32'(exp_ip));
                chk({sc, exp_ret ? " R9 cs" : " R7 cs"}, 32'(new_cs), 32'(exp_cs));
                chk({sc, exp_ret ? " R9 flags" : " R8 flags"}, 32'(new_flags), 32'(exp_flags));
                chk({sc, " R6 sp"}, 32'(new_sp), 32'(exp_sp));
                chk({sc, " R10 busy low at done"}, 32'(busy), 0);
            end
        end
        chk({sc, " R10 done seen"}, 32'(seen), 1);
        chk({sc, " R10 busy cycles"}, 32'(bcnt), 32'(exp_busy));
        chk({sc, " R5 all ops seen"}, 32'(eq_addr.size()), 0);
        eq_addr.delete(); eq_we.delete(); eq_data.delete();
    endtask

    task automatic quiet(input int n, input string sc);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            chk({sc, " no activity"}, 32'({busy, done, mem_req}), 0);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1; boundary = 0; iret = 0; intr = 0; nmi = 0; swi_req = 0;
        swi_type = 8'h21; ack_type = 8'h40;
        flags_r = 16'h0000; cs_r = 16'h1234; ip_r = 16'h0100;
        ss_r = 16'h2000; sp_r = 16'h0800;
        for (int t = 0; t < 256; t++) begin
            if (t == 1 || t == 2 || t == 8'h21 || t == 8'h40) begin
                mem[t*4]     = 16'(16'hA000 + t);
                mem[t*4 + 2] = 16'(16'hC000 + t);
            end
        end
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R11 reset state
        @(negedge clk);
        chk("R11 busy after reset", 32'(busy), 0);
        chk("R11 done after reset", 32'(done), 0);
        chk("R11 mem_req after reset", 32'(mem_req), 0);

        // R11 no pending NMI: boundary with nothing requested
        strobe(1, 0, 0);
        quiet(3, "R11 boundary with no source");

        // R2 maskable blocked when bit 9 clear
        intr = 1'b1;
        strobe(1, 0, 0);
        quiet(3, "R2 masked intr");

        // R1 requests between boundaries ignored
        flags_r = 16'h0201;
        @(negedge clk); swi_req = 1'b1;
        quiet(4, "R1 between boundaries");
        swi_req = 1'b0;

        // R2 maskable accepted with bit 9 set, type from ack input
        model_entry(8'h40);
        strobe(1, 0, 0);
        observe("R2 intr entry");

        // R3 NMI edge latched between boundaries, bit 9 clear
        intr = 1'b0; flags_r = 16'h0000;
        @(negedge clk); nmi = 1'b1;
        quiet(3, "R3 nmi latched, R1 no boundary");
        model_entry(8'd2);
        strobe(1, 0, 0);
        observe("R3 nmi entry");
        strobe(1, 0, 0);
        quiet(3, "R3 held level no retrigger");

        // R4 all four sources at one boundary: NMI wins
        @(negedge clk); nmi = 1'b0;
        @(negedge clk);
        flags_r = 16'h0300; intr = 1'b1;
        model_entry(8'd2);
        @(negedge clk);
        nmi = 1'b1; boundary = 1'b1; swi_req = 1'b1;
        @(posedge clk); #1; boundary = 1'b0; swi_req = 1'b0;
        observe("R4 nmi over all");

        // R4 software over trap and maskable
        model_entry(8'h21);
        strobe(1, 0, 1);
        observe("R4 swi over trap");

        // R4 trap over maskable
        model_entry(8'd1);
        strobe(1, 0, 0);
        observe("R4 trap over intr");

        // R3 edge during busy is kept for the next boundary
        intr = 1'b0; nmi = 1'b0; flags_r = 16'h0000;
        @(negedge clk);
        model_entry(8'h21);
        strobe(1, 0, 1);
        fork
            observe("R3 swi with nmi in flight");
            begin
                repeat (2) @(negedge clk);
                nmi = 1'b1;
            end
        join
        model_entry(8'd2);
        strobe(1, 0, 0);
        observe("R3 nmi after busy");
        nmi = 1'b0;

        // R6 push with SP=0 wraps to 0xFFFE
        flags_r = 16'h8AD5; cs_r = 16'h5A5A; ip_r = 16'h0F0F;
        ss_r = 16'h3000; sp_r = 16'h0000; swi_type = 8'h21;
        model_entry(8'h21);
        strobe(1, 0, 1);
        observe("R6 wrap entry");

        // R9 round trip: pop the frame just written
        sp_r = 16'hFFFA;
        model_return();
        chk("R8 saved flags original", 32'(exp_flags), 32'h8AD5);
        strobe(0, 1, 0);
        observe("R9 return round trip");

        // R6 pop wraps past 0xFFFE
        mem[int'(pa(16'h3000, 16'h0000))] = 16'h7E7E;
        sp_r = 16'hFFFC;
        model_return();
        strobe(0, 1, 0);
        observe("R6 wrap return");

        // R12 return beats a same-cycle boundary
        sp_r = 16'h0400;
        mem[int'(pa(16'h3000, 16'h0400))] = 16'h1111;
        mem[int'(pa(16'h3000, 16'h0402))] = 16'h2222;
        mem[int'(pa(16'h3000, 16'h0404))] = 16'h0246;
        model_return();
        strobe(1, 1, 1);
        observe("R12 iret with boundary");
        quiet(2, "R12 boundary dropped");

        finish_run();
    end
endmodule